// File: doc/BRIEF.md
# Privileged Register Access Checker

This block decides, in a single combinational pass, what happens to one read or one write aimed at the control register of a selectable system performance monitor. It looks at the privilege level of the requester, which higher levels exist or are enabled, the per-monitor 2-bit grant fields that levels 1, 2 and 3 program, the enable bits each level holds, a host-routing flag, fine-grained trap controls and the access direction. It answers with one of three outcomes: allow the access, raise an undefined-instruction exception, or trap to level 1, 2 or 3 with a fixed syndrome class.

The checks form a strict priority chain. Reads only need a grant that is not zero, while writes need the full grant. An optional priority flag pulls the level-3 checks to the head of the chain and turns their failure into an undefined result. The block carries no state and no handshake: every output is valid in the same cycle as its inputs, so a pipeline stage around it is the user's choice. Performing the register access itself is left to the caller.

Top module: `priv_acc_checker`

## Requirements
- R1: When `mon_feat_i` is 0, every access, at any level, gives kind undefined (2'b01).
- R2: With the feature present, an access at level 3 (`cur_lvl_i` = 3) is always allowed (kind 2'b00), whatever the other inputs.
- R3: The grant of a level for the selected monitor is bits [2*sel+1 : 2*sel] of that level's grant field; a select value of NUM_MON or above reads as grant 2'b00.
- R4: A read is refused by a grant of 2'b00 only; a write is refused by any grant other than 2'b11.
- R5: When `l3_prio_i` is 1 and `lvl3_impl_i` is 1, at levels 0, 1 and 2 a clear `l3_en_i` or a refusing level-3 grant gives undefined ahead of every other check.
- R6: At level 0, a clear `l1_en_i`, or a refusing level-1 grant while `l0_host_i` is 0, traps to level 2 when `lvl2_on_i` and `host_route_i` are both 1, and to level 1 otherwise; in host mode the level-1 grant is ignored.
- R7: At level 1, and at level 0 outside host mode, with `lvl2_on_i` and `fgt_feat_i` set, the access traps to level 2 when either `fgt_l3_en_i` is 0 with level 3 implemented, or the per-direction fine-grained bit (`fgt_rd_i` for reads, `fgt_wr_i` for writes) is 0.
- R8: At levels 0 and 1 with `lvl2_on_i` set, a clear `l2_en_i` or a refusing level-2 grant traps to level 2.
- R9: Without the priority path, with level 3 implemented, a clear `l3_en_i` or refusing level-3 grant traps to level 3, or gives undefined when `l3_undef_i` is 1.
- R10: At level 2 only the level-3 checks apply; level-1, fine-grained and level-2 controls have no effect on the outcome.
- R11: The checks at levels 0 and 1 take effect in this order: level-1 checks, fine-grained check, level-2 enable, level-2 grant, level-3 enable and grant; the first failing check decides.
- R12: Outcome encoding: `kind_o` 2'b00 allow, 2'b01 undefined, 2'b10 trap (2'b11 never occurs); a trap drives `syn_o` = 6'h18 and `tgt_lvl_o` 1 to 3; otherwise `tgt_lvl_o` and `syn_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_feat_i | input | 1 | Monitor feature present |
| cur_lvl_i | input | 2 | Privilege level of the requester, 0 to 3 |
| lvl2_on_i | input | 1 | Level 2 implemented and enabled |
| lvl3_impl_i | input | 1 | Level 3 implemented |
| is_wr_i | input | 1 | 1 for a write, 0 for a read |
| mon_sel_i | input | SEL_W | Index of the selected monitor |
| grant_l1_i | input | 2*NUM_MON | Level-1 grant field, two bits per monitor |
| grant_l2_i | input | 2*NUM_MON | Level-2 grant field, two bits per monitor |
| grant_l3_i | input | 2*NUM_MON | Level-3 grant field, two bits per monitor |
| l1_en_i | input | 1 | Level-1 enable of level-0 access |
| l2_en_i | input | 1 | Level-2 enable of lower-level access |
| l3_en_i | input | 1 | Level-3 enable of lower-level access |
| host_route_i | input | 1 | Route level-0 enable traps to level 2 |
| l0_host_i | input | 1 | Level 0 runs in host mode |
| fgt_feat_i | input | 1 | Fine-grained trap feature present |
| fgt_l3_en_i | input | 1 | Level-3 enable of the fine-grained controls |
| fgt_rd_i | input | 1 | Fine-grained read bit, 0 traps |
| fgt_wr_i | input | 1 | Fine-grained write bit, 0 traps |
| l3_prio_i | input | 1 | Move level-3 checks first as undefined |
| l3_undef_i | input | 1 | Level-3 failures give undefined instead of a trap |
| kind_o | output | 2 | Outcome kind |
| tgt_lvl_o | output | 2 | Trap target level |
| syn_o | output | 6 | Syndrome class |

## Verification
Every result of this block is due in the same cycle as the inputs that cause it, with no register on the path. The bench therefore changes all inputs together just after a rising clock edge and reads the three outputs at the following falling edge, half a period later, so each check sees settled values of exactly one stimulus. Directed cases walk each step of the priority chain with only the step under test failing, then seeded random vectors are compared against a reference function built from the requirements.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;

  typedef enum logic [1:0] {
    KIND_ALLOW = 2'b00,
    KIND_UNDEF = 2'b01,
    KIND_TRAP  = 2'b10
  } acc_kind_e;

  localparam logic [5:0] SYN_CLASS = 6'h18;

  localparam logic [1:0] GRANT_NONE = 2'b00;
  localparam logic [1:0] GRANT_FULL = 2'b11;

  // A read is refused only by an empty grant; a write needs the full grant.
  function automatic logic grant_refuses(input logic [1:0] g, input logic wr);
    if (wr) return g != GRANT_FULL;
    return g == GRANT_NONE;
  endfunction

  typedef struct packed {
    acc_kind_e  kind;
    logic [1:0] tgt;
    logic [5:0] syn;
  } acc_verdict_t;

endpackage

// File: rtl/acc_grant_pick.sv
module acc_grant_pick #(
  parameter int NUM_MON = 6,
  parameter int SEL_W   = 3,
  localparam int FLD_W  = 2 * NUM_MON
) (
  input  logic [FLD_W-1:0] field_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [1:0]       grant_o
);

  logic [1:0] slot [NUM_MON];

  for (genvar m = 0; m < NUM_MON; m++) begin : g_slot
    assign slot[m] = field_i[2*m +: 2];
  end

  always_comb begin
    grant_o = 2'b00;
    for (int m = 0; m < NUM_MON; m++) begin
      if (sel_i == SEL_W'(m)) grant_o = slot[m];
    end
  end

endmodule

// File: rtl/acc_upper_gate.sv
module acc_upper_gate
  import acc_chk_pkg::*;
(
  input  logic       lvl3_impl_i,
  input  logic       l3_en_i,
  input  logic [1:0] grant_l3_i,
  input  logic       is_wr_i,
  output logic       l3_fail_o
);

  always_comb begin
    l3_fail_o = lvl3_impl_i && (!l3_en_i || grant_refuses(grant_l3_i, is_wr_i));
  end

  always_comb begin
    // R9
    if (!lvl3_impl_i) l3_absent_quiet_chk: assert (!l3_fail_o);
  end

endmodule

// File: rtl/acc_lower_gate.sv
module acc_lower_gate
  import acc_chk_pkg::*;
(
  input  logic [1:0] cur_lvl_i,
  input  logic       lvl2_on_i,
  input  logic       lvl3_impl_i,
  input  logic       is_wr_i,
  input  logic [1:0] grant_l1_i,
  input  logic [1:0] grant_l2_i,
  input  logic       l1_en_i,
  input  logic       l2_en_i,
  input  logic       host_route_i,
  input  logic       l0_host_i,
  input  logic       fgt_feat_i,
  input  logic       fgt_l3_en_i,
  input  logic       fgt_rd_i,
  input  logic       fgt_wr_i,
  output logic       hit_o,
  output logic [1:0] tgt_o
);

  logic at_l0, at_low, l1_fail, fgt_fail, l2en_fail, l2g_fail, fgt_bit;

  always_comb begin
    at_l0   = (cur_lvl_i == 2'd0);
    at_low  = (cur_lvl_i == 2'd0) || (cur_lvl_i == 2'd1);
    fgt_bit = is_wr_i ? fgt_wr_i : fgt_rd_i;

    l1_fail   = at_l0 && (!l1_en_i || (!l0_host_i && grant_refuses(grant_l1_i, is_wr_i)));
    fgt_fail  = at_low && lvl2_on_i && !(at_l0 && l0_host_i) && fgt_feat_i &&
                ((lvl3_impl_i && !fgt_l3_en_i) || !fgt_bit);
    l2en_fail = at_low && lvl2_on_i && !l2_en_i;
    l2g_fail  = at_low && lvl2_on_i && grant_refuses(grant_l2_i, is_wr_i);
  end

  // First failing check in chain order decides the target.
  always_comb begin
    hit_o = 1'b0;
    tgt_o = 2'd0;
    if (l1_fail) begin
      hit_o = 1'b1;
      tgt_o = (lvl2_on_i && host_route_i) ? 2'd2 : 2'd1;
    end else if (fgt_fail || l2en_fail || l2g_fail) begin
      hit_o = 1'b1;
      tgt_o = 2'd2;
    end
  end

  always_comb begin
    // R10
    if (cur_lvl_i[1]) lower_idle_high_chk: assert (!hit_o);
    // R6
    if (hit_o) lower_target_range_chk: assert (tgt_o == 2'd1 || tgt_o == 2'd2);
    // R8
    if (hit_o && !at_l0) lower_l1_only_l2_chk: assert (tgt_o == 2'd2);
  end

endmodule

// File: rtl/priv_acc_checker.sv
module priv_acc_checker
  import acc_chk_pkg::*;
#(
  parameter int NUM_MON = 6,
  parameter int SEL_W   = 3,
  localparam int FLD_W  = 2 * NUM_MON
) (
  input  logic             mon_feat_i,
  input  logic [1:0]       cur_lvl_i,
  input  logic             lvl2_on_i,
  input  logic             lvl3_impl_i,
  input  logic             is_wr_i,
  input  logic [SEL_W-1:0] mon_sel_i,
  input  logic [FLD_W-1:0] grant_l1_i,
  input  logic [FLD_W-1:0] grant_l2_i,
  input  logic [FLD_W-1:0] grant_l3_i,
  input  logic             l1_en_i,
  input  logic             l2_en_i,
  input  logic             l3_en_i,
  input  logic             host_route_i,
  input  logic             l0_host_i,
  input  logic             fgt_feat_i,
  input  logic             fgt_l3_en_i,
  input  logic             fgt_rd_i,
  input  logic             fgt_wr_i,
  input  logic             l3_prio_i,
  input  logic             l3_undef_i,
  output logic [1:0]       kind_o,
  output logic [1:0]       tgt_lvl_o,
  output logic [5:0]       syn_o
);

  logic [1:0] g_l1, g_l2, g_l3;
  logic       l3_fail, low_hit;
  logic [1:0] low_tgt;
  acc_verdict_t verdict;

  localparam int LVL_N = 3;
  logic [FLD_W-1:0] fields [LVL_N];
  logic [1:0]       picks  [LVL_N];

  assign fields[0] = grant_l1_i;
  assign fields[1] = grant_l2_i;
  assign fields[2] = grant_l3_i;

  for (genvar l = 0; l < LVL_N; l++) begin : g_pick
    acc_grant_pick #(.NUM_MON(NUM_MON), .SEL_W(SEL_W)) u_pick (
      .field_i (fields[l]),
      .sel_i   (mon_sel_i),
      .grant_o (picks[l])
    );
  end

  assign g_l1 = picks[0];
  assign g_l2 = picks[1];
  assign g_l3 = picks[2];

  acc_upper_gate u_upper (
    .lvl3_impl_i (lvl3_impl_i),
    .l3_en_i     (l3_en_i),
    .grant_l3_i  (g_l3),
    .is_wr_i     (is_wr_i),
    .l3_fail_o   (l3_fail)
  );

  acc_lower_gate u_lower (
    .cur_lvl_i    (cur_lvl_i),
    .lvl2_on_i    (lvl2_on_i),
    .lvl3_impl_i  (lvl3_impl_i),
    .is_wr_i      (is_wr_i),
    .grant_l1_i   (g_l1),
    .grant_l2_i   (g_l2),
    .l1_en_i      (l1_en_i),
    .l2_en_i      (l2_en_i),
    .host_route_i (host_route_i),
    .l0_host_i    (l0_host_i),
    .fgt_feat_i   (fgt_feat_i),
    .fgt_l3_en_i  (fgt_l3_en_i),
    .fgt_rd_i     (fgt_rd_i),
    .fgt_wr_i     (fgt_wr_i),
    .hit_o        (low_hit),
    .tgt_o        (low_tgt)
  );

  always_comb begin
    verdict = '{kind: KIND_ALLOW, tgt: 2'd0, syn: 6'd0};
    if (!mon_feat_i) begin
      verdict.kind = KIND_UNDEF;
    end else if (cur_lvl_i == 2'd3) begin
      verdict.kind = KIND_ALLOW;
    end else if (l3_prio_i && l3_fail) begin
      verdict.kind = KIND_UNDEF;
    end else if (low_hit) begin
      verdict = '{kind: KIND_TRAP, tgt: low_tgt, syn: SYN_CLASS};
    end else if (l3_fail) begin
      if (l3_undef_i) verdict.kind = KIND_UNDEF;
      else            verdict = '{kind: KIND_TRAP, tgt: 2'd3, syn: SYN_CLASS};
    end
  end

  assign kind_o    = verdict.kind;
  assign tgt_lvl_o = verdict.tgt;
  assign syn_o     = verdict.syn;

  always_comb begin
    // R1
    if (!mon_feat_i) no_feature_undef_chk: assert (kind_o == KIND_UNDEF);
    // R2
    if (mon_feat_i && cur_lvl_i == 2'd3) top_level_allow_chk: assert (kind_o == KIND_ALLOW);
    // R12
    if (kind_o == KIND_TRAP) trap_syndrome_chk: assert (syn_o == 6'h18 && tgt_lvl_o != 2'd0);
    // R12
    if (kind_o != KIND_TRAP) quiet_fields_chk: assert (syn_o == 6'd0 && tgt_lvl_o == 2'd0);
    // R12
    kind_legal_chk: assert (kind_o != 2'b11);
  end

endmodule

// File: tb/sim_priv_acc_checker.sv
module sim_priv_acc_checker;

  localparam int NUM_MON = 6;
  localparam int SEL_W   = 3;
  localparam int FLD_W   = 2 * NUM_MON;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             mon_feat, lvl2_on, lvl3_impl, is_wr;
  logic [1:0]       cur_lvl;
  logic [SEL_W-1:0] sel;
  logic [FLD_W-1:0] gf1, gf2, gf3;
  logic l1_en, l2_en, l3_en, host_route, l0_host;
  logic fgt_feat, fgt_l3_en, fgt_rd, fgt_wr, l3_prio, l3_undef;
  logic [1:0] kind, tgt;
  logic [5:0] syn;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  priv_acc_checker #(.NUM_MON(NUM_MON), .SEL_W(SEL_W)) u0 (
    .mon_feat_i(mon_feat), .cur_lvl_i(cur_lvl), .lvl2_on_i(lvl2_on),
    .lvl3_impl_i(lvl3_impl), .is_wr_i(is_wr), .mon_sel_i(sel),
    .grant_l1_i(gf1), .grant_l2_i(gf2), .grant_l3_i(gf3),
    .l1_en_i(l1_en), .l2_en_i(l2_en), .l3_en_i(l3_en),
    .host_route_i(host_route), .l0_host_i(l0_host),
    .fgt_feat_i(fgt_feat), .fgt_l3_en_i(fgt_l3_en), .fgt_rd_i(fgt_rd),
    .fgt_wr_i(fgt_wr), .l3_prio_i(l3_prio), .l3_undef_i(l3_undef),
    .kind_o(kind), .tgt_lvl_o(tgt), .syn_o(syn)
  );

  function automatic logic [1:0] pick(input logic [FLD_W-1:0] f, input logic [SEL_W-1:0] s);
    if (int'(s) >= NUM_MON) return 2'b00;
    return f[2*int'(s) +: 2];
  endfunction

  function automatic logic refuse(input logic [1:0] g, input logic wr);
    return wr ? (g != 2'b11) : (g == 2'b00);
  endfunction

  // Expected {kind, tgt, syn} from the requirements.
  function automatic logic [9:0] model();
    logic f3;
    f3 = lvl3_impl && (!l3_en || refuse(pick(gf3, sel), is_wr));
    if (!mon_feat) return {2'b01, 2'd0, 6'd0};
    if (cur_lvl == 2'd3) return {2'b00, 2'd0, 6'd0};
    if (l3_prio && f3) return {2'b01, 2'd0, 6'd0};
    if (cur_lvl == 2'd0 && (!l1_en || (!l0_host && refuse(pick(gf1, sel), is_wr))))
      return {2'b10, (lvl2_on && host_route) ? 2'd2 : 2'd1, 6'h18};
    if (cur_lvl != 2'd2 && lvl2_on) begin
      if (!(cur_lvl == 2'd0 && l0_host) && fgt_feat &&
          ((lvl3_impl && !fgt_l3_en) || !(is_wr ? fgt_wr : fgt_rd)))
        return {2'b10, 2'd2, 6'h18};
      if (!l2_en || refuse(pick(gf2, sel), is_wr)) return {2'b10, 2'd2, 6'h18};
    end
    if (f3) return l3_undef ? {2'b01, 2'd0, 6'd0} : {2'b10, 2'd3, 6'h18};
    return {2'b00, 2'd0, 6'd0};
  endfunction

  task automatic defaults();
    mon_feat = 1; cur_lvl = 2'd1; lvl2_on = 1; lvl3_impl = 1; is_wr = 0; sel = 3'd2;
    gf1 = '1; gf2 = '1; gf3 = '1; l1_en = 1; l2_en = 1; l3_en = 1;
    host_route = 0; l0_host = 0; fgt_feat = 1; fgt_l3_en = 1; fgt_rd = 1; fgt_wr = 1;
    l3_prio = 0; l3_undef = 0;
  endtask

  // Apply after a rising edge, compare at the following falling edge.
  task automatic check(input string req, input logic [9:0] exp);
    @(negedge clk);
    checks++;
    if ({kind, tgt, syn} !== exp) begin
      errors++;
      $display("FAIL %s: got kind=%b tgt=%0d syn=%h expected kind=%b tgt=%0d syn=%h",
               req, kind, tgt, syn, exp[9:8], exp[7:6], exp[5:0]);
    end
    @(posedge clk);
  endtask

  localparam logic [9:0] ALLOW = {2'b00, 2'd0, 6'd0};
  localparam logic [9:0] UNDEF = {2'b01, 2'd0, 6'd0};
  localparam logic [9:0] TRAP1 = {2'b10, 2'd1, 6'h18};
  localparam logic [9:0] TRAP2 = {2'b10, 2'd2, 6'h18};
  localparam logic [9:0] TRAP3 = {2'b10, 2'd3, 6'h18};

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    defaults();
    @(posedge clk);
    check("R12 idle allow", ALLOW);

    mon_feat = 0; cur_lvl = 2'd3;
    check("R1 no feature level3", UNDEF);
    cur_lvl = 2'd0;
    check("R1 no feature level0", UNDEF);

    defaults(); cur_lvl = 2'd3; gf3 = '0; l3_en = 0; l3_prio = 1; l1_en = 0;
    check("R2 level3 allowed", ALLOW);

    // R3: grant of monitor 4 is 01 (bits 9:8), others full
    defaults(); sel = 3'd4; is_wr = 1; gf2 = 12'b11_01_11_11_11_11;
    check("R3 write refused by slot4 grant", TRAP2);
    is_wr = 0;
    check("R4 read allowed by grant 01", ALLOW);
    sel = 3'd3;
    is_wr = 1;
    check("R3 neighbour slot full", ALLOW);
    sel = 3'd7; is_wr = 0;
    check("R3 out-of-range select reads 00", TRAP2);

    defaults(); is_wr = 1; gf3 = {6{2'b10}};
    check("R4 write needs 11", TRAP3);
    is_wr = 0; gf3 = '0;
    check("R4 read refused by 00", TRAP3);

    defaults(); cur_lvl = 2'd0; l1_en = 0; fgt_rd = 0; l2_en = 0; l3_prio = 1; l3_en = 0;
    check("R5 priority undefined first", UNDEF);
    cur_lvl = 2'd2;
    check("R5 priority at level2", UNDEF);
    lvl3_impl = 0; cur_lvl = 2'd1; l2_en = 1; fgt_rd = 1;
    check("R5 no level3 skips priority", ALLOW);

    defaults(); cur_lvl = 2'd0; l1_en = 0;
    check("R6 level0 trap to 1", TRAP1);
    host_route = 1;
    check("R6 host route to 2", TRAP2);
    lvl2_on = 0;
    check("R6 route needs level2", TRAP1);
    defaults(); cur_lvl = 2'd0; l0_host = 1; gf1 = '0;
    check("R6 host mode ignores l1 grant", ALLOW);
    l0_host = 0;
    check("R6 l1 grant refuses", TRAP1);

    defaults(); fgt_rd = 0;
    check("R7 read fgt bit", TRAP2);
    is_wr = 1;
    check("R7 write ignores read bit", ALLOW);
    fgt_wr = 0;
    check("R7 write fgt bit", TRAP2);
    defaults(); fgt_l3_en = 0;
    check("R7 level3 fgt enable", TRAP2);
    lvl3_impl = 0;
    check("R7 fgt enable needs level3", ALLOW);
    defaults(); fgt_rd = 0; fgt_feat = 0;
    check("R7 feature absent", ALLOW);
    defaults(); cur_lvl = 2'd0; l0_host = 1; fgt_rd = 0;
    check("R7 host mode skips fgt", ALLOW);

    defaults(); l2_en = 0;
    check("R8 level2 enable", TRAP2);
    lvl2_on = 0;
    check("R8 level2 off", ALLOW);

    defaults(); l3_en = 0;
    check("R9 level3 trap", TRAP3);
    l3_undef = 1;
    check("R9 undef mode", UNDEF);

    defaults(); cur_lvl = 2'd2; l1_en = 0; fgt_rd = 0; l2_en = 0; gf2 = '0;
    check("R10 level2 ignores lower checks", ALLOW);
    l3_en = 0;
    check("R10 level2 level3 trap", TRAP3);

    defaults(); cur_lvl = 2'd0; l1_en = 0; fgt_rd = 0; l3_en = 0;
    check("R11 l1 before fgt", TRAP1);
    l1_en = 1; l2_en = 0;
    check("R11 fgt before l2/l3", TRAP2);
    fgt_rd = 1; l2_en = 1; gf2 = '0;
    check("R11 l2 grant before l3", TRAP2);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      mon_feat = ($urandom % 16) != 0;
      cur_lvl = 2'($urandom); lvl2_on = 1'($urandom); lvl3_impl = 1'($urandom);
      is_wr = 1'($urandom); sel = 3'($urandom);
      gf1 = FLD_W'($urandom); gf2 = FLD_W'($urandom); gf3 = FLD_W'($urandom);
      l1_en = ($urandom % 4) != 0; l2_en = ($urandom % 4) != 0; l3_en = ($urandom % 4) != 0;
      host_route = 1'($urandom); l0_host = 1'($urandom);
      fgt_feat = 1'($urandom); fgt_l3_en = ($urandom % 4) != 0;
      fgt_rd = ($urandom % 4) != 0; fgt_wr = ($urandom % 4) != 0;
      l3_prio = 1'($urandom); l3_undef = 1'($urandom);
      check("R11 random chain", model());
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule